// File: doc/BRIEF.md
# Masked Machine/Supervisor Control-Register File

This block keeps the privileged status, interrupt-pending, interrupt-enable, interrupt-delegation, trap-vector and counter-enable control registers of a processor hart. A single access port carries a 12-bit register address, write data, a write strobe and a read strobe. Every write goes through a per-field filter, so read-only or unimplemented bits never change. The read path is combinational. It shows the current contents together with derived fields.

The supervisor-level registers have no storage of their own. Each one is a narrowed window onto the machine register behind it. The status window exposes only a fixed subset of fields. The pending and enable windows are cut down further by the interrupt delegation register, for both reads and writes. The top status bit is never stored. It is recomputed on every read from the floating-point and extension state fields.

Top module: `csr_unit`

## Requirements
- R1: A write to the machine status register (address 0x040) changes only bits 1, 3, 5, 7, 8, 13-14, 17 and 18, plus bits 15-16 when HAS_EXT is set. All other stored bits keep the value zero.
- R2: Status bits 12-11 (previous privilege) take the written value only when that value is 0, 1 or 3. A written 2 leaves the field as it was, while the rest of the write still applies.
- R3: Bit XLEN-1 of a status read (address 0x040 or 0x140) is 1 exactly when bits 14-13 or bits 16-15 equal 3. Writing that bit has no effect.
- R4: A write to the machine pending register (0x044) changes only bits 1 and 5. Every other pending bit reads 0.
- R5: The machine enable register (0x042) accepts bits 1, 3, 5, 7, 9 and 12. The delegation register (0x043) accepts bits 1, 5, 9 and 12. Other bits read 0.
- R6: A read of the supervisor pending register (0x144) or supervisor enable register (0x142) returns the machine register ANDed with the delegation register. A write through either one changes only delegated bits, within the machine register's own write mask.
- R7: A read of the supervisor status register (0x140) returns bits 1, 5, 8, 13-16 and 18 of the machine status, plus the bit from R3. A write to it changes only those bits.
- R8: The machine trap vector (0x045) and the supervisor trap vector (0x145) store the written value with bits 1-0 forced to 0.
- R9: The user counter-enable register (0x046) and the supervisor counter-enable register (0x146) keep only the written bits 2-0. Higher bits read 0.
- R10: When an access (read or write strobe) targets an address outside the eleven listed above, csr_illegal is 1 in that cycle, csr_rdata is 0, and a write changes no register. With neither strobe active, csr_illegal is 0.
- R11: A write takes effect at the rising clock edge. During the write cycle, csr_rdata shows the value from before the write.
- R12: After reset, every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write strobe |
| csr_re | input | 1 | Read strobe |
| csr_rdata | output | XLEN | Read data for csr_addr (combinational) |
| csr_illegal | output | 1 | Access to an unimplemented address |

## Verification
The bench builds the block with XLEN = 32 and HAS_EXT = 1. The 32-bit width places the derived dirty summary at bit 31, where a plain write of that bit can be checked against it. The extension flag makes bits 15-16 writable, so the dirty summary can be driven from either state field. With HAS_EXT = 1, a supervisor-window write also reaches those bits.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

  localparam int ADDR_W = 12;
  localparam int STAT_W = 19;
  localparam int IRQ_W  = 13;
  localparam int NREG   = 11;

  // register slots
  localparam int I_MSTAT  = 0;
  localparam int I_SSTAT  = 1;
  localparam int I_MPEND  = 2;
  localparam int I_SPEND  = 3;
  localparam int I_MENAB  = 4;
  localparam int I_SENAB  = 5;
  localparam int I_IDELEG = 6;
  localparam int I_MVEC   = 7;
  localparam int I_SVEC   = 8;
  localparam int I_UCEN   = 9;
  localparam int I_SCEN   = 10;

  // status field positions
  localparam int MPP_LO = 11;
  localparam int FS_LO  = 13;
  localparam int XS_LO  = 15;

  localparam logic [STAT_W-1:0] M_STAT_WR = 19'h661AA;
  localparam logic [STAT_W-1:0] M_XS      = 19'h18000;
  localparam logic [STAT_W-1:0] M_MPP     = 19'h01800;
  localparam logic [STAT_W-1:0] M_SVIEW   = 19'h5E122;

  localparam logic [IRQ_W-1:0] M_IRQ_ALL  = 13'h12AA;
  localparam logic [IRQ_W-1:0] M_IRQ_DLG  = 13'h1222;
  localparam logic [IRQ_W-1:0] M_IRQ_SWP  = 13'h0022;

  function automatic logic [ADDR_W-1:0] slot_addr(input int i);
    logic [ADDR_W-1:0] a;
    case (i)
      I_MSTAT:  a = 12'h040;
      I_SSTAT:  a = 12'h140;
      I_MPEND:  a = 12'h044;
      I_SPEND:  a = 12'h144;
      I_MENAB:  a = 12'h042;
      I_SENAB:  a = 12'h142;
      I_IDELEG: a = 12'h043;
      I_MVEC:   a = 12'h045;
      I_SVEC:   a = 12'h145;
      I_UCEN:   a = 12'h046;
      I_SCEN:   a = 12'h146;
      default:  a = 12'hFFF;
    endcase
    return a;
  endfunction

  function automatic logic priv_legal(input logic [1:0] p);
    return p != 2'b10;
  endfunction

  function automatic logic [STAT_W-1:0] stat_merge(
      input logic [STAT_W-1:0] old, input logic [STAT_W-1:0] wr,
      input logic [STAT_W-1:0] mask);
    return (old & ~mask) | (wr & mask);
  endfunction

  function automatic logic [STAT_W-1:0] stat_write(
      input logic [STAT_W-1:0] old, input logic [STAT_W-1:0] wr,
      input logic has_ext);
    logic [STAT_W-1:0] mask;
    mask = M_STAT_WR;
    if (has_ext) mask = mask | M_XS;
    if (priv_legal(wr[MPP_LO +: 2])) mask = mask | M_MPP;
    return stat_merge(old, wr, mask);
  endfunction

  function automatic logic stat_dirty(input logic [STAT_W-1:0] s);
    return (s[FS_LO +: 2] == 2'b11) || (s[XS_LO +: 2] == 2'b11);
  endfunction

  function automatic logic [IRQ_W-1:0] irq_merge(
      input logic [IRQ_W-1:0] old, input logic [IRQ_W-1:0] wr,
      input logic [IRQ_W-1:0] mask);
    return (old & ~mask) | (wr & mask);
  endfunction

endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec
  import csr_unit_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              access,
  output logic [NREG-1:0]   sel,
  output logic              illegal
);

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    assign sel[i] = (addr == slot_addr(i));
  end

  assign illegal = access && (sel == '0);

endmodule

// File: rtl/csr_status_reg.sv
module csr_status_reg
  import csr_unit_pkg::*;
#(
  parameter bit HAS_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_m,
  input  logic              wr_s,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] stat_q,
  output logic              dirty
);

  logic [STAT_W-1:0] stat_d;
  logic [STAT_W-1:0] sview_wr;
  logic              mpp_reject;

  assign sview_wr   = stat_merge(stat_q, wdata, M_SVIEW);
  assign mpp_reject = wr_m && !priv_legal(wdata[MPP_LO +: 2]);

  always_comb begin
    stat_d = stat_q;
    if (wr_m)      stat_d = stat_write(stat_q, wdata, HAS_EXT);
    else if (wr_s) stat_d = stat_write(stat_q, sview_wr, HAS_EXT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign dirty = stat_dirty(stat_q);

  a_r2_mpp_never_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[MPP_LO +: 2] != 2'b10);

  a_r2_reserved_mpp_kept: assert property (@(posedge clk) disable iff (!rst_n)
    mpp_reject |=> stat_q[MPP_LO +: 2] == $past(stat_q[MPP_LO +: 2]));

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_m || wr_s) |=> $stable(stat_q));

  a_r1_fixed_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~(M_STAT_WR | M_XS | M_MPP)) == '0);

  a_r7_sview_outside_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && !wr_m) |=> (stat_q & ~M_SVIEW) == ($past(stat_q) & ~M_SVIEW));

  if (!HAS_EXT) begin : g_noext
    a_r1_xs_zero: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[XS_LO +: 2] == 2'b00);
  end

endmodule

// File: rtl/csr_irq_regs.sv
module csr_irq_regs
  import csr_unit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mp,
  input  logic             wr_sp,
  input  logic             wr_me,
  input  logic             wr_se,
  input  logic             wr_dlg,
  input  logic [IRQ_W-1:0] wdata,
  output logic [IRQ_W-1:0] pend_q,
  output logic [IRQ_W-1:0] enab_q,
  output logic [IRQ_W-1:0] dlg_q
);

  logic [IRQ_W-1:0] pend_src, enab_src;
  logic             pend_wr, enab_wr;

  // supervisor writes are first narrowed to delegated bits
  assign pend_src = wr_sp ? irq_merge(pend_q, wdata, dlg_q) : wdata;
  assign enab_src = wr_se ? irq_merge(enab_q, wdata, dlg_q) : wdata;
  assign pend_wr  = wr_mp || wr_sp;
  assign enab_wr  = wr_me || wr_se;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      enab_q <= '0;
      dlg_q  <= '0;
    end else begin
      if (pend_wr) pend_q <= irq_merge(pend_q, pend_src, M_IRQ_SWP);
      if (enab_wr) enab_q <= irq_merge(enab_q, enab_src, M_IRQ_ALL);
      if (wr_dlg)  dlg_q  <= wdata & M_IRQ_DLG;
    end
  end

  a_r4_hw_pending_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~M_IRQ_SWP) == '0);

  a_r5_deleg_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (dlg_q & ~M_IRQ_DLG) == '0);

  a_r5_enab_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (enab_q & ~M_IRQ_ALL) == '0);

  a_r6_spend_keeps_undelegated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sp && !wr_mp) |=> (pend_q & ~$past(dlg_q)) == ($past(pend_q) & ~$past(dlg_q)));

  a_r6_senab_keeps_undelegated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_se && !wr_me) |=> (enab_q & ~$past(dlg_q)) == ($past(enab_q) & ~$past(dlg_q)));

endmodule

// File: rtl/csr_plain_regs.sv
module csr_plain_regs #(
  parameter int XLEN  = 64,
  parameter int CEN_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           vec_wr,
  input  logic [1:0]           cen_wr,
  input  logic [XLEN-1:0]      wdata,
  output logic [1:0][XLEN-1:0] vec_q,
  output logic [1:0][CEN_W-1:0] cen_q
);

  localparam int NVEC = 2;
  localparam int NCEN = 2;

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         vec_q[v] <= '0;
      else if (vec_wr[v]) vec_q[v] <= {wdata[XLEN-1:2], 2'b00};
    end

    a_r8_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      vec_q[v][1:0] == 2'b00);

    a_r8_vec_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
      vec_wr[v] |=> vec_q[v][XLEN-1:2] == $past(wdata[XLEN-1:2]));
  end

  for (genvar c = 0; c < NCEN; c++) begin : g_cen
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cen_q[c] <= '0;
      else if (cen_wr[c]) cen_q[c] <= wdata[CEN_W-1:0];
    end

    a_r9_cen_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cen_wr[c] |=> $stable(cen_q[c]));
  end

endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_unit_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit HAS_EXT = 1'b1,
  parameter int CEN_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            csr_we,
  input  logic            csr_re,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal
);

  logic [NREG-1:0]        sel;
  logic [NREG-1:0]        wr;
  logic [STAT_W-1:0]      stat_q;
  logic                   dirty;
  logic [IRQ_W-1:0]       pend_q, enab_q, dlg_q;
  logic [1:0][XLEN-1:0]   vec_q;
  logic [1:0][CEN_W-1:0]  cen_q;

  csr_addr_dec u_dec (
    .addr    (csr_addr),
    .access  (csr_we || csr_re),
    .sel     (sel),
    .illegal (csr_illegal)
  );

  assign wr = sel & {NREG{csr_we}};

  csr_status_reg #(.HAS_EXT(HAS_EXT)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_m   (wr[I_MSTAT]),
    .wr_s   (wr[I_SSTAT]),
    .wdata  (csr_wdata[STAT_W-1:0]),
    .stat_q (stat_q),
    .dirty  (dirty)
  );

  csr_irq_regs u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_mp  (wr[I_MPEND]),
    .wr_sp  (wr[I_SPEND]),
    .wr_me  (wr[I_MENAB]),
    .wr_se  (wr[I_SENAB]),
    .wr_dlg (wr[I_IDELEG]),
    .wdata  (csr_wdata[IRQ_W-1:0]),
    .pend_q (pend_q),
    .enab_q (enab_q),
    .dlg_q  (dlg_q)
  );

  csr_plain_regs #(.XLEN(XLEN), .CEN_W(CEN_W)) u_plain (
    .clk    (clk),
    .rst_n  (rst_n),
    .vec_wr ({wr[I_SVEC], wr[I_MVEC]}),
    .cen_wr ({wr[I_SCEN], wr[I_UCEN]}),
    .wdata  (csr_wdata),
    .vec_q  (vec_q),
    .cen_q  (cen_q)
  );

  always_comb begin
    csr_rdata = '0;
    if (sel[I_MSTAT]) begin
      csr_rdata[STAT_W-1:0] = stat_q;
      csr_rdata[XLEN-1]     = dirty;
    end else if (sel[I_SSTAT]) begin
      csr_rdata[STAT_W-1:0] = stat_q & M_SVIEW;
      csr_rdata[XLEN-1]     = dirty;
    end else if (sel[I_MPEND]) begin
      csr_rdata[IRQ_W-1:0] = pend_q;
    end else if (sel[I_SPEND]) begin
      csr_rdata[IRQ_W-1:0] = pend_q & dlg_q;
    end else if (sel[I_MENAB]) begin
      csr_rdata[IRQ_W-1:0] = enab_q;
    end else if (sel[I_SENAB]) begin
      csr_rdata[IRQ_W-1:0] = enab_q & dlg_q;
    end else if (sel[I_IDELEG]) begin
      csr_rdata[IRQ_W-1:0] = dlg_q;
    end else if (sel[I_MVEC]) begin
      csr_rdata = vec_q[0];
    end else if (sel[I_SVEC]) begin
      csr_rdata = vec_q[1];
    end else if (sel[I_UCEN]) begin
      csr_rdata[CEN_W-1:0] = cen_q[0];
    end else if (sel[I_SCEN]) begin
      csr_rdata[CEN_W-1:0] = cen_q[1];
    end
  end

  a_r10_illegal_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> csr_rdata == '0);

  a_r10_illegal_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_illegal && csr_we) |=> ($stable(stat_q) && $stable(pend_q) && $stable(enab_q)
                                 && $stable(dlg_q) && $stable(vec_q) && $stable(cen_q)));

  a_r10_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  a_r3_sd_follows_state: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[I_MSTAT] || sel[I_SSTAT]) |->
      csr_rdata[XLEN-1] == ((csr_rdata[FS_LO +: 2] == 2'b11) || (csr_rdata[XS_LO +: 2] == 2'b11)));

endmodule

// File: tb/test_csr_unit.sv
module test_csr_unit;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [11:0]     csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic            csr_we = 1'b0;
  logic            csr_re = 1'b0;
  logic [XLEN-1:0] csr_rdata;
  logic            csr_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] ms, mp, me, md, mv, sv, uc, sc;
  logic [31:0] lfsr = 32'hC0FFEE11;

  always #10 clk = ~clk;

  csr_unit #(.XLEN(XLEN), .HAS_EXT(1'b1), .CEN_W(3)) i_csr_unit (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_re(csr_re), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal)
  );

  function automatic bit known(input logic [11:0] a);
    return a inside {12'h040, 12'h140, 12'h044, 12'h144, 12'h042, 12'h142,
                     12'h043, 12'h045, 12'h145, 12'h046, 12'h146};
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [31:0] r;
    logic sd;
    sd = (ms[14:13] == 2'b11) || (ms[16:15] == 2'b11);
    r = 32'h0;
    case (a)
      12'h040: begin r = ms; r[31] = sd; end
      12'h140: begin
        r[1] = ms[1]; r[5] = ms[5]; r[8] = ms[8];
        r[16:13] = ms[16:13]; r[18] = ms[18]; r[31] = sd;
      end
      12'h044: r = mp;
      12'h144: r = mp & md;
      12'h042: r = me;
      12'h142: r = me & md;
      12'h043: r = md;
      12'h045: r = mv;
      12'h145: r = sv;
      12'h046: r = uc;
      12'h146: r = sc;
      default: r = 32'h0;
    endcase
    return r;
  endfunction

  task automatic st_upd(input logic [31:0] w);
    ms[1] = w[1]; ms[3] = w[3]; ms[5] = w[5]; ms[7] = w[7]; ms[8] = w[8];
    ms[14:13] = w[14:13]; ms[16:15] = w[16:15]; ms[17] = w[17]; ms[18] = w[18];
    if (w[12:11] != 2'b10) ms[12:11] = w[12:11];
  endtask

  task automatic m_apply(input logic [11:0] a, input logic [31:0] w);
    logic [31:0] t;
    case (a)
      12'h040: st_upd(w);
      12'h140: begin
        t = ms;
        t[1] = w[1]; t[5] = w[5]; t[8] = w[8]; t[16:13] = w[16:13]; t[18] = w[18];
        st_upd(t);
      end
      12'h044: begin mp[1] = w[1]; mp[5] = w[5]; end
      12'h144: begin
        if (md[1]) mp[1] = w[1];
        if (md[5]) mp[5] = w[5];
      end
      12'h042: for (int b = 0; b < 32; b++) if (b inside {1, 3, 5, 7, 9, 12}) me[b] = w[b];
      12'h142: for (int b = 0; b < 32; b++) if ((b inside {1, 3, 5, 7, 9, 12}) && md[b]) me[b] = w[b];
      12'h043: begin
        md = 32'h0;
        for (int b = 0; b < 32; b++) if (b inside {1, 5, 9, 12}) md[b] = w[b];
      end
      12'h045: mv = {w[31:2], 2'b00};
      12'h145: sv = {w[31:2], 2'b00};
      12'h046: uc = {29'h0, w[2:0]};
      12'h146: sc = {29'h0, w[2:0]};
      default: ;
    endcase
  endtask

  task automatic do_op(input logic [11:0] a, input logic [31:0] w,
                       input logic we, input logic re, input string tag);
    logic [31:0] exp_d;
    logic exp_i;
    @(negedge clk);
    csr_addr = a; csr_wdata = w; csr_we = we; csr_re = re;
    #2;
    exp_d = m_read(a);
    exp_i = (we || re) && !known(a);
    checks++;
    if (csr_rdata !== exp_d) begin
      errors++;
      $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, a, csr_rdata, exp_d);
    end
    checks++;
    if (csr_illegal !== exp_i) begin
      errors++;
      $display("FAIL %s illegal addr=%h actual=%b expected=%b", tag, a, csr_illegal, exp_i);
    end
    @(posedge clk);
    if (we && known(a)) m_apply(a, w);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    do_op(a, 32'h0, 1'b0, 1'b1, tag);
  endtask

  task automatic wr_rd(input logic [11:0] a, input logic [31:0] w, input string tag);
    do_op(a, w, 1'b1, 1'b0, tag);
    rd(a, tag);
  endtask

  function automatic logic [11:0] pick_addr(input logic [31:0] r);
    logic [11:0] a;
    case (r[3:0])
      4'd0: a = 12'h040;  4'd1: a = 12'h140;  4'd2: a = 12'h044;
      4'd3: a = 12'h144;  4'd4: a = 12'h042;  4'd5: a = 12'h142;
      4'd6: a = 12'h043;  4'd7: a = 12'h045;  4'd8: a = 12'h145;
      4'd9: a = 12'h046;  4'd10: a = 12'h146; 4'd11: a = 12'h041;
      default: a = 12'h040;
    endcase
    return a;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    ms = 0; mp = 0; me = 0; md = 0; mv = 0; sv = 0; uc = 0; sc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R12: reset values
    foreach (known_list[i]) rd(known_list[i], "R12 reset");

    // R1: all-ones status write
    wr_rd(12'h040, 32'hFFFF_FFFF, "R1 status mask");
    // R2: reserved previous-privilege value
    wr_rd(12'h040, 32'h0000_1000, "R2 reserved mpp kept");
    wr_rd(12'h040, 32'h0000_0800, "R2 legal mpp");
    // R3: dirty summary
    wr_rd(12'h040, 32'h0000_6000, "R3 fs dirty");
    wr_rd(12'h040, 32'h0001_8000, "R3 xs dirty");
    wr_rd(12'h040, 32'h0000_2000, "R3 not dirty");
    wr_rd(12'h040, 32'h8000_0000, "R3 sd not stored");
    // R7: supervisor status window
    wr_rd(12'h040, 32'h0000_0088, "R7 setup");
    wr_rd(12'h140, 32'hFFFF_FFFF, "R7 sview write");
    rd(12'h040, "R7 machine view after");
    wr_rd(12'h140, 32'h0000_0000, "R7 sview clear");
    rd(12'h040, "R7 machine view kept");
    // R5: enable and delegation masks
    wr_rd(12'h043, 32'hFFFF_FFFF, "R5 deleg mask");
    wr_rd(12'h042, 32'hFFFF_FFFF, "R5 enable mask");
    // R4: pending software bits
    wr_rd(12'h044, 32'hFFFF_FFFF, "R4 pending mask");
    // R6: supervisor interrupt windows
    wr_rd(12'h043, 32'h0000_0020, "R6 deleg stip only");
    rd(12'h144, "R6 spend view");
    wr_rd(12'h144, 32'h0000_0000, "R6 spend write");
    rd(12'h044, "R6 mpend after");
    wr_rd(12'h142, 32'h0000_0000, "R6 senab write");
    rd(12'h042, "R6 menab after");
    // R8: vectors
    wr_rd(12'h045, 32'hFFFF_FFFF, "R8 mvec");
    wr_rd(12'h145, 32'h1234_5677, "R8 svec");
    // R9: counter enables
    wr_rd(12'h046, 32'hFFFF_FFFF, "R9 ucen");
    wr_rd(12'h146, 32'hFFFF_FFF5, "R9 scen");
    // R10: unmapped addresses
    do_op(12'h7FF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R10 illegal write");
    do_op(12'h000, 32'h0, 1'b0, 1'b1, "R10 illegal read");
    do_op(12'h041, 32'h0, 1'b0, 1'b0, "R10 no access");
    foreach (known_list[i]) rd(known_list[i], "R10 nothing changed");
    // R11: old value visible during write cycle, new one after
    do_op(12'h045, 32'hA5A5_0004, 1'b1, 1'b1, "R11 write cycle old");
    rd(12'h045, "R11 new value");

    // R11 random mix against the reference model
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      do_op(pick_addr(lfsr), {lfsr[15:0], lfsr[31:16]} ^ 32'h5A3C_0F96,
            lfsr[5], lfsr[6] | ~lfsr[5], "R11 random");
    end

    @(negedge clk);
    csr_we = 1'b0; csr_re = 1'b0;
    done = 1;
    summary();
    $finish;
  end

  logic [11:0] known_list [11] = '{12'h040, 12'h140, 12'h044, 12'h144, 12'h042,
                                   12'h142, 12'h043, 12'h045, 12'h145, 12'h046, 12'h146};

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule